// File: doc/BRIEF.md
# Programmable Chip Select Unit

This block turns a 32-bit bus address and a 3-bit address-space code into one of four active-low chip selects. It also produces the internal acknowledge that ends the access. Each channel holds a base register and a mask register, both loaded over a write-only register port. The two registers set the channel's address block, its address-space filter, write protection, fast termination, wait-state count and port width. Channel 0 doubles as a boot decode. From reset it claims every access until software sets its valid bit.

Accesses use a valid/ready handshake. The block takes a request when `acc_valid` and `acc_ready` are both high at a clock edge. `acc_ready` stays low from that edge until the cycle after the acknowledge, and a request held during that time waits without effect. The selected chip select is asserted from the cycle after acceptance through the acknowledge cycle. The acknowledge is a one-cycle pulse whose code reports the port width. An access that matches no channel produces no select and no acknowledge. A write that lands on a protected channel produces only a one-cycle fault flag.

Top module: `csel_unit`

## Requirements
- R1: After reset, every `cs_n` bit is 1, `ack` is 00, `lanes` is 00, `wp_fault` is 0 and `acc_ready` is 1.
- R2: From reset until channel 0's base register is written with bit 7 (valid) set, channel 0 matches every access, whatever its address, space code or direction.
- R3: Once channel 0's valid bit has been written to 1, the boot decode never returns. Any channel whose valid bit (base bit 7) is clear never asserts.
- R4: Address match is checked on bits 31:8 only. A bit counts only where mask register bits 31:8 hold 0, and there it must equal base register bits 31:8. Address bits 7:0 never affect the match.
- R5: The access space code must equal base bits 2:0 in every position where the space mask (mask bits 7:5) is 0.
- R6: When several channels match, only the lowest-numbered one asserts. At most one `cs_n` bit is ever low.
- R7: If the winning channel has write protect (base bit 6) set and the access is a write, no select and no acknowledge occur. `wp_fault` is 1 for exactly the one cycle after acceptance. Reads to the same channel are unaffected.
- R8: With fast termination (base bit 5) clear, the acknowledge appears in cycle N+1+W. Here N is the first cycle with the select asserted and W is mask bits 1:0.
- R9: With fast termination set, the acknowledge appears in cycle N, whatever W is.
- R10: The acknowledge code is 01 for an 8-bit port (mask bit 4 = 0) and 10 for a 16-bit port (mask bit 4 = 1). It is 00 in every other cycle.
- R11: While a select is asserted, `lanes` (bit 1 = data 15:8, bit 0 = data 7:0) is 10 for an 8-bit port. For a 16-bit port it is 11 for a word, 10 for a byte at an even address and 01 for a byte at an odd address. It is 00 when no select is asserted.
- R12: `acc_ready` is low from acceptance through the acknowledge cycle. The select holds its value during that time, and a held request is taken only once `acc_ready` is high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Bits 2:1 select the channel; bit 0 selects the register: 0 = base, 1 = mask |
| reg_wdata | input | 32 | Register write data |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Block can accept an access |
| acc_addr | input | 32 | Access address |
| acc_space | input | 3 | Access address-space code |
| acc_write | input | 1 | 1 = write access |
| acc_word | input | 1 | 1 = 16-bit access, 0 = byte |
| cs_n | output | 4 | Active-low chip selects, one per channel |
| ack | output | 2 | Internal acknowledge code |
| lanes | output | 2 | Active data byte lanes |
| wp_fault | output | 1 | One-cycle write-protect violation |

## Verification
The hardest cases need several channels programmed to overlap. One example is a write that fails the space filter of a readable channel and falls through to a lower-priority, write-protected channel covering a large block. Another is a request held high through a long wait-state access.

The stimulus first uses the boot decode before channel 0 is valid. It then programs channels of nested sizes: a 2 GB fast, protected channel under a 512 MB space-filtered channel and smaller blocks. It checks fall-through, fault and hold behaviour by cycle count, and finally clears valid bits so the remaining channels take over.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int CS_AW   = 32;
  localparam int CS_SW   = 3;
  localparam int CS_GRAN = 8;
  localparam int CS_WW   = 2;
  localparam int CS_BW   = CS_AW - CS_GRAN;
  localparam int CS_CW   = CS_WW + 1;

  // base register fields
  localparam int B_VALID = 7;
  localparam int B_WP    = 6;
  localparam int B_FAST  = 5;
  localparam int B_SPC   = 0;
  // mask register fields
  localparam int M_SMASK = 5;
  localparam int M_WIDE  = 4;
  localparam int M_WAIT  = 0;

  typedef struct packed {
    logic [CS_BW-1:0] base;
    logic             valid;
    logic             wp;
    logic             fast;
    logic [CS_SW-1:0] space;
    logic [CS_BW-1:0] amask;
    logic [CS_SW-1:0] smask;
    logic             wide;
    logic [CS_WW-1:0] waits;
  } chan_cfg_t;

  typedef enum logic [1:0] {
    ACK_NONE = 2'b00,
    ACK_BYTE = 2'b01,
    ACK_WORD = 2'b10
  } ack_code_t;

  function automatic logic [1:0] lane_map(input logic wide, input logic word, input logic a0);
    if (!wide)     return 2'b10;
    else if (word) return 2'b11;
    else if (a0)   return 2'b01;
    else           return 2'b10;
  endfunction
endpackage

// File: rtl/csel_regs.sv
module csel_regs
  import csel_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int RA_W = $clog2(NUM_CH) + 1,
  localparam int IW   = RA_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [RA_W-1:0]  addr,
  input  logic [CS_AW-1:0] wdata,
  output chan_cfg_t        cfg [NUM_CH],
  output logic             boot
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    chan_cfg_t r;
    logic      hit_me;
    assign hit_me  = we && (addr[RA_W-1:1] == IW'(ch));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r <= '0;
      end else if (hit_me) begin
        if (!addr[0]) begin
          r.base  <= wdata[CS_AW-1:CS_GRAN];
          r.valid <= wdata[B_VALID];
          r.wp    <= wdata[B_WP];
          r.fast  <= wdata[B_FAST];
          r.space <= wdata[B_SPC +: CS_SW];
        end else begin
          r.amask <= wdata[CS_AW-1:CS_GRAN];
          r.smask <= wdata[M_SMASK +: CS_SW];
          r.wide  <= wdata[M_WIDE];
          r.waits <= wdata[M_WAIT +: CS_WW];
        end
      end
    end
    assign cfg[ch] = r;
  end

  // boot decode stays on until channel 0 is first marked valid
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   boot <= 1'b1;
    else if (we && addr == '0 && wdata[B_VALID])  boot <= 1'b0;
  end
endmodule

// File: rtl/csel_match.sv
module csel_match
  import csel_pkg::*;
(
  input  chan_cfg_t        cfg,
  input  logic             boot_en,
  input  logic [CS_AW-1:0] addr,
  input  logic [CS_SW-1:0] space,
  output logic             hit
);
  logic addr_ok, space_ok;
  always_comb begin
    addr_ok  = (((addr[CS_AW-1:CS_GRAN] ^ cfg.base) & ~cfg.amask) == '0);
    space_ok = (((space ^ cfg.space) & ~cfg.smask) == '0);
    hit      = boot_en | (cfg.valid & addr_ok & space_ok);
  end
endmodule

// File: rtl/csel_pick.sv
module csel_pick #(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH-1:0] hits,
  output logic [NUM_CH-1:0] grant,
  output logic              any
);
  always_comb begin
    grant = '0;
    any   = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (hits[i] && !any) begin
        grant[i] = 1'b1;
        any      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/csel_seq.sv
module csel_seq
  import csel_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_word,
  input  logic              acc_a0,
  input  logic [NUM_CH-1:0] grant,
  input  logic              any,
  input  chan_cfg_t         sel,
  output logic              acc_ready,
  output logic [NUM_CH-1:0] cs_n,
  output logic [1:0]        ack,
  output logic [1:0]        lanes,
  output logic              wp_fault
);
  logic              busy;
  logic [CS_CW-1:0]  cnt;
  logic [NUM_CH-1:0] cs_q;
  logic              wide_q;
  logic [1:0]        lanes_q;
  logic              take, blocked, start;

  assign take    = acc_valid && !busy;
  assign blocked = any && sel.wp && acc_write;
  assign start   = take && any && !blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      cs_q     <= '0;
      wide_q   <= 1'b0;
      lanes_q  <= 2'b00;
      wp_fault <= 1'b0;
    end else begin
      wp_fault <= take && blocked;
      if (start) begin
        busy    <= 1'b1;
        cs_q    <= grant;
        wide_q  <= sel.wide;
        lanes_q <= lane_map(sel.wide, acc_word, acc_a0);
        cnt     <= sel.fast ? '0 : ({1'b0, sel.waits} + CS_CW'(1));
      end else if (busy) begin
        if (cnt == '0) begin
          busy    <= 1'b0;
          cs_q    <= '0;
          lanes_q <= 2'b00;
        end else begin
          cnt <= cnt - CS_CW'(1);
        end
      end
    end
  end

  always_comb begin
    ack = ACK_NONE;
    if (busy && cnt == '0) ack = wide_q ? ACK_WORD : ACK_BYTE;
  end

  assign acc_ready = !busy;
  assign cs_n      = ~cs_q;
  assign lanes     = lanes_q;
endmodule

// File: rtl/csel_unit.sv
module csel_unit
  import csel_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_we,
  input  logic [$clog2(NUM_CH):0]   reg_addr,
  input  logic [31:0]               reg_wdata,
  input  logic                      acc_valid,
  output logic                      acc_ready,
  input  logic [31:0]               acc_addr,
  input  logic [2:0]                acc_space,
  input  logic                      acc_write,
  input  logic                      acc_word,
  output logic [NUM_CH-1:0]         cs_n,
  output logic [1:0]                ack,
  output logic [1:0]                lanes,
  output logic                      wp_fault
);
  chan_cfg_t         cfg [NUM_CH];
  logic              boot;
  logic [NUM_CH-1:0] hits, grant;
  logic              any;
  chan_cfg_t         sel;

  csel_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .cfg(cfg), .boot(boot)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_dec
    logic boot_en;
    if (ch == 0) begin : g_boot
      assign boot_en = boot;
    end else begin : g_plain
      assign boot_en = 1'b0;
    end
    csel_match u_match (
      .cfg(cfg[ch]), .boot_en(boot_en), .addr(acc_addr),
      .space(acc_space), .hit(hits[ch])
    );
  end

  csel_pick #(.NUM_CH(NUM_CH)) u_pick (.hits(hits), .grant(grant), .any(any));

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_CH; i++) if (grant[i]) sel = cfg[i];
  end

  csel_seq #(.NUM_CH(NUM_CH)) u_seq (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_word(acc_word), .acc_a0(acc_addr[0]), .grant(grant), .any(any),
    .sel(sel), .acc_ready(acc_ready), .cs_n(cs_n), .ack(ack),
    .lanes(lanes), .wp_fault(wp_fault)
  );
endmodule

// File: rtl/csel_unit_chk.sv
module csel_unit_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_ready,
  input logic [NUM_CH-1:0] cs_n,
  input logic [1:0]        ack,
  input logic [1:0]        lanes,
  input logic              wp_fault
);
  assert_cs_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  assert_ack_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack != 2'b00) |-> (ack == 2'b01 || ack == 2'b10));

  assert_ack_needs_cs_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ack != 2'b00) |-> (cs_n != '1));

  assert_ready_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ready |-> (cs_n == '1 && ack == 2'b00));

  assert_cs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_ready && ack == 2'b00) |=> $stable(cs_n));

  assert_fault_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wp_fault |-> (cs_n == '1 && ack == 2'b00));

  assert_lanes_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n == '1) |-> (lanes == 2'b00));

  assert_lanes_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != '1) |-> (lanes != 2'b00));
endmodule

bind csel_unit csel_unit_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_ready(acc_ready), .cs_n(cs_n),
  .ack(ack), .lanes(lanes), .wp_fault(wp_fault)
);

// File: tb/tb_csel_unit.sv
module tb_csel_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [31:0] acc_addr = '0;
  logic [2:0]  acc_space = '0;
  logic        acc_write = 1'b0;
  logic        acc_word = 1'b0;
  logic [3:0]  cs_n;
  logic [1:0]  ack;
  logic [1:0]  lanes;
  logic        wp_fault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  csel_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_addr(acc_addr), .acc_space(acc_space), .acc_write(acc_write),
    .acc_word(acc_word), .cs_n(cs_n), .ack(ack), .lanes(lanes),
    .wp_fault(wp_fault)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int ch, input bit msk, input logic [31:0] val);
    @(negedge clk);
    reg_we    = 1'b1;
    reg_addr  = {ch[1:0], msk};
    reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // one access; exp_lat < 0 means no bus cycle is expected
  task automatic do_access(input logic [31:0] a, input logic [2:0] sp, input bit w, input bit wd,
                           input logic [3:0] exp_cs, input int exp_lat, input logic [1:0] exp_ack,
                           input logic [1:0] exp_lanes, input bit exp_fault, input string req);
    int lat;
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_space = sp; acc_write = w; acc_word = wd;
    @(negedge clk);
    acc_valid = 1'b0;
    check(cs_n == exp_cs, {req, " select"}, 32'(cs_n), 32'(exp_cs));
    check(wp_fault == exp_fault, {req, " fault"}, 32'(wp_fault), 32'(exp_fault));
    if (exp_lat < 0) begin
      check(ack == 2'b00 && acc_ready, {req, " no cycle"}, {ack, acc_ready}, 3'b001);
      @(negedge clk);
      check(wp_fault == 1'b0, {req, " fault one cycle"}, 32'(wp_fault), 0);
      return;
    end
    check(lanes == exp_lanes, {req, " lanes R11"}, 32'(lanes), 32'(exp_lanes));
    lat = 0;
    while (ack == 2'b00 && lat < 8) begin
      check(!acc_ready && cs_n == exp_cs, {req, " hold R12"}, {cs_n, acc_ready}, {exp_cs, 1'b0});
      @(negedge clk);
      lat++;
    end
    check(lat == exp_lat, {req, " latency"}, lat, exp_lat);
    check(ack == exp_ack, {req, " ack R10"}, 32'(ack), 32'(exp_ack));
    @(negedge clk);
    check(cs_n == 4'hF && acc_ready && lanes == 2'b00, {req, " release R12"},
          {cs_n, acc_ready, lanes}, {4'hF, 1'b1, 2'b00});
  endtask

  task automatic t_reset;
    check(cs_n == 4'hF && ack == 2'b00 && lanes == 2'b00 && !wp_fault && acc_ready,
          "R1 reset state", {cs_n, ack, lanes, wp_fault, acc_ready}, {4'hF, 2'b00, 2'b00, 1'b0, 1'b1});
  endtask

  task automatic t_boot;
    do_access(32'hFFFF_0000, 3'd5, 1'b1, 1'b0, 4'hE, 1, 2'b01, 2'b10, 1'b0, "R2 boot high write");
    do_access(32'h1234_5677, 3'd0, 1'b0, 1'b1, 4'hE, 1, 2'b01, 2'b10, 1'b0, "R2 boot read");
    // channel 1 valid while boot still on: channel 0 still wins
    wr_reg(1, 1'b0, 32'h0010_0080);
    wr_reg(1, 1'b1, 32'h0000_FFE0);
    do_access(32'h0010_0004, 3'd5, 1'b0, 1'b0, 4'hE, 1, 2'b01, 2'b10, 1'b0, "R6 boot priority");
  endtask

  task automatic t_decode;
    wr_reg(0, 1'b1, 32'h0000_0F12);   // 4 KB, 16-bit, 2 waits
    wr_reg(0, 1'b0, 32'h0000_0086);   // base 0, valid, space 6
    do_access(32'h0000_0ABC, 3'd6, 1'b0, 1'b1, 4'hE, 3, 2'b10, 2'b11, 1'b0, "R8 ch0 word");
    do_access(32'h0000_0ABC, 3'd5, 1'b0, 1'b1, 4'hF, -1, 2'b00, 2'b00, 1'b0, "R5 ch0 wrong space");
    do_access(32'h0000_1000, 3'd6, 1'b0, 1'b0, 4'hF, -1, 2'b00, 2'b00, 1'b0, "R3 boot ended");
    do_access(32'h0010_0005, 3'd5, 1'b0, 1'b1, 4'hD, 1, 2'b01, 2'b10, 1'b0, "R10 ch1 8-bit");
    do_access(32'h0010_FFFF, 3'd1, 1'b1, 1'b0, 4'hD, 1, 2'b01, 2'b10, 1'b0, "R4 ch1 top byte");
    do_access(32'h0011_0000, 3'd1, 1'b0, 1'b0, 4'hF, -1, 2'b00, 2'b00, 1'b0, "R4 ch1 outside");
    do_access(32'h0010_00FF, 3'd0, 1'b0, 1'b0, 4'hD, 1, 2'b01, 2'b10, 1'b0, "R4 low bits ignored");
  endtask

  task automatic t_space;
    wr_reg(2, 1'b0, 32'h2000_0084);   // 512 MB at 0x2000_0000, space 4
    wr_reg(2, 1'b1, 32'h1FFF_FF71);   // space mask 011, 16-bit, 1 wait
    do_access(32'h3000_0002, 3'd7, 1'b0, 1'b0, 4'hB, 2, 2'b10, 2'b10, 1'b0, "R5 ch2 space 7");
    do_access(32'h3000_0003, 3'd4, 1'b1, 1'b0, 4'hB, 2, 2'b10, 2'b01, 1'b0, "R11 ch2 odd byte");
    do_access(32'h3000_0002, 3'd3, 1'b0, 1'b0, 4'hF, -1, 2'b00, 2'b00, 1'b0, "R5 ch2 space 3");
  endtask

  task automatic t_prot_fast;
    wr_reg(3, 1'b0, 32'h0000_00E0);   // base 0, valid, wp, fast, space 0
    wr_reg(3, 1'b1, 32'h7FFF_FFF3);   // 2 GB, any space, 16-bit, 3 waits
    do_access(32'h4000_0000, 3'd0, 1'b0, 1'b1, 4'h7, 0, 2'b10, 2'b11, 1'b0, "R9 fast read");
    do_access(32'h4000_0000, 3'd2, 1'b1, 1'b1, 4'hF, -1, 2'b00, 2'b00, 1'b1, "R7 protected write");
    do_access(32'h0010_0004, 3'd5, 1'b1, 1'b0, 4'hD, 1, 2'b01, 2'b10, 1'b0, "R6 ch1 over ch3");
    do_access(32'h3000_0002, 3'd2, 1'b1, 1'b0, 4'hF, -1, 2'b00, 2'b00, 1'b1, "R7 fall-through write");
    do_access(32'h3000_0002, 3'd2, 1'b0, 1'b0, 4'h7, 0, 2'b10, 2'b10, 1'b0, "R7 read unaffected");
    do_access(32'h8000_0000, 3'd0, 1'b0, 1'b0, 4'hF, -1, 2'b00, 2'b00, 1'b0, "R4 above ch3");
  endtask

  task automatic t_hold;
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = 32'h0000_0ABC; acc_space = 3'd6; acc_write = 1'b0; acc_word = 1'b1;
    @(negedge clk);
    acc_addr = 32'h0010_0004; acc_space = 3'd5;   // held request for channel 1
    for (int i = 0; i < 3; i++) begin
      check(cs_n == 4'hE && !acc_ready && ack == 2'b00, "R12 held during wait",
            {cs_n, acc_ready, ack}, {4'hE, 1'b0, 2'b00});
      @(negedge clk);
    end
    check(cs_n == 4'hE && ack == 2'b10, "R8 ack after 2 waits", {cs_n, ack}, {4'hE, 2'b10});
    @(negedge clk);
    check(cs_n == 4'hF && acc_ready, "R12 gap before next", {cs_n, acc_ready}, {4'hF, 1'b1});
    @(negedge clk);
    acc_valid = 1'b0;
    check(cs_n == 4'hD && !acc_ready, "R12 held request taken", {cs_n, acc_ready}, {4'hD, 1'b0});
    @(negedge clk);
    check(ack == 2'b01, "R10 held ack", 32'(ack), 1);
    @(negedge clk);
    check(cs_n == 4'hF && acc_ready, "R12 idle", {cs_n, acc_ready}, {4'hF, 1'b1});
  endtask

  task automatic t_invalidate;
    wr_reg(2, 1'b0, 32'h2000_0004);   // ch2 valid clear
    do_access(32'h3000_0002, 3'd7, 1'b0, 1'b0, 4'h7, 0, 2'b10, 2'b10, 1'b0, "R3 ch2 disabled");
    wr_reg(0, 1'b0, 32'h0000_0006);   // ch0 valid clear, boot stays off
    do_access(32'h0000_0ABC, 3'd6, 1'b0, 1'b0, 4'h7, 0, 2'b10, 2'b10, 1'b0, "R3 ch0 disabled");
    do_access(32'hF000_0000, 3'd6, 1'b0, 1'b0, 4'hF, -1, 2'b00, 2'b00, 1'b0, "R3 no boot return");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_boot();
    t_decode();
    t_space();
    t_prot_fast();
    t_hold();
    t_invalidate();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule